// File: doc/BRIEF.md
# Fast-Interrupt Enable and Status Bank

This block sits between a vector of level-sensitive interrupt sources and the fast-interrupt request input of a processor. Software programs a mask that selects which sources may raise the request. The request line goes high whenever any selected source is active. The mask is never rewritten as a whole. Bits are set through one register and cleared through a separate, write-only register, so each handler can change its own bit without a read-modify-write sequence.

A software-interrupt configuration register lets firmware raise a programmed source. One field is merged into source bit 1 of the fast vector. Another field is driven out to the companion normal-interrupt bank. Software can read the raw source vector and the masked status vector. Prioritisation and vectoring are left to the handler.

All accesses go through a plain 32-bit read/write port. Reads are combinational and writes take effect at the clock edge.

Top module: `fiq_bank`

## Requirements
- R1: After reset, the enable mask, the software configuration, `fiqReq` and `swIrqOut` are all 0.
- R2: A write to offset 0x108 sets every enable bit for which the written data bit is 1. Enable bits written with 0 keep their value. A read of 0x108 returns the mask.
- R3: A write to offset 0x10C clears every enable bit for which the written data bit is 1 and leaves the other bits unchanged. A read of 0x10C returns 0.
- R4: A read of offset 0x100 returns the raw source vector ANDed with the enable mask. Writes to 0x100 change no state.
- R5: `fiqReq` is registered. After each clock edge it equals the OR of the status bits as they stood before that edge.
- R6: Offset 0x110 holds the software configuration. Data bit 2 forces raw source bit 1 high while it is set. Data bit 1 drives `swIrqOut`. A read returns these two bits at positions 2 and 1, and all other bits read 0.
- R7: A read of offset 0x104 returns `srcIn`, with bit 1 ORed with software configuration bit 2. Writes to 0x104 change no state.
- R8: A read of an unmapped offset returns 0, and a write to one changes no state. `rdData` is 0 whenever `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational |
| srcIn | input | 32 | Raw level interrupt sources |
| fiqReq | output | 1 | Registered fast-interrupt request |
| swIrqOut | output | 1 | Programmed normal-interrupt source |

## Verification
The bench writes set patterns and clear patterns over an enable mask that is already partly set. If the design treated either register as a plain store, bits written with 0 would change. It checks that the request lags a source change by exactly one edge; a combinational path or an extra stage would fail this in the cycle around the change. It raises the programmed source while the physical bit 1 is low, checks that the raw view and the status view both show it, and checks that reserved configuration bits read back as 0. It also writes to read-only and unmapped offsets; a design with a loose decode would corrupt the mask.

// File: rtl/fiq_bank_pkg.sv
package fiq_bank_pkg;
  localparam int unsigned OFS_STATUS = 32'h100;
  localparam int unsigned OFS_RAW    = 32'h104;
  localparam int unsigned OFS_ENSET  = 32'h108;
  localparam int unsigned OFS_ENCLR  = 32'h10C;
  localparam int unsigned OFS_SWCFG  = 32'h110;

  localparam int unsigned SW_FIQ_BIT = 2;
  localparam int unsigned SW_IRQ_BIT = 1;
  localparam int unsigned SW_SRC_IDX = 1;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_RAW,
    RD_ENABLE,
    RD_SWCFG
  } rdSel_e;

  typedef struct packed {
    logic   setEn;
    logic   clrEn;
    logic   swWr;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/fiq_bank_ctrl.sv
module fiq_bank_ctrl
  import fiq_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);
  logic hitEnSet, hitEnClr, hitSw, hitStatus, hitRaw;

  assign hitStatus = (addr == ADDR_W'(OFS_STATUS));
  assign hitRaw    = (addr == ADDR_W'(OFS_RAW));
  assign hitEnSet  = (addr == ADDR_W'(OFS_ENSET));
  assign hitEnClr  = (addr == ADDR_W'(OFS_ENCLR));
  assign hitSw     = (addr == ADDR_W'(OFS_SWCFG));

  always_comb begin
    strobe.setEn = wrEn && hitEnSet;
    strobe.clrEn = wrEn && hitEnClr;
    strobe.swWr  = wrEn && hitSw;
    strobe.rdSel = RD_NONE;
    if (rdEn) begin
      if (hitStatus)     strobe.rdSel = RD_STATUS;
      else if (hitRaw)   strobe.rdSel = RD_RAW;
      else if (hitEnSet) strobe.rdSel = RD_ENABLE;
      else if (hitSw)    strobe.rdSel = RD_SWCFG;
    end
  end

  assert_write_strobes_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setEn, strobe.clrEn, strobe.swWr}));

  assert_no_read_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> strobe.rdSel == RD_NONE);
endmodule

// File: rtl/fiq_bank_dp.sv
module fiq_bank_dp
  import fiq_bank_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               fiqReq,
  output logic               swIrqOut
);
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] rawVec;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] swInject;
  logic               swFiq, swIrq;
  logic [DATA_W-1:0]  swCfgView;

  always_comb begin
    swInject = '0;
    swInject[SW_SRC_IDX] = swFiq;
  end

  assign rawVec    = srcIn | swInject;
  assign statusVec = rawVec & enMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
    end else if (strobe.clrEn) begin
      enMask <= enMask & ~wrData[NUM_SRC-1:0];
    end else if (strobe.setEn) begin
      enMask <= enMask | wrData[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swFiq <= 1'b0;
      swIrq <= 1'b0;
    end else if (strobe.swWr) begin
      swFiq <= wrData[SW_FIQ_BIT];
      swIrq <= wrData[SW_IRQ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fiqReq <= 1'b0;
    else       fiqReq <= |statusVec;
  end

  assign swIrqOut = swIrq;

  always_comb begin
    swCfgView = '0;
    swCfgView[SW_FIQ_BIT] = swFiq;
    swCfgView[SW_IRQ_BIT] = swIrq;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_STATUS: rdData = DATA_W'(statusVec);
      RD_RAW:    rdData = DATA_W'(rawVec);
      RD_ENABLE: rdData = DATA_W'(enMask);
      RD_SWCFG:  rdData = swCfgView;
      default:   rdData = '0;
    endcase
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |=> (enMask & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0]));

  assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |=> (enMask & $past(enMask)) == $past(enMask));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEn |=> (enMask & $past(wrData[NUM_SRC-1:0])) == '0);

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setEn && !strobe.clrEn |=> $stable(enMask));

  assert_req_lag_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fiqReq == $past(|statusVec));
endmodule

// File: rtl/fiq_bank.sv
module fiq_bank
  import fiq_bank_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               fiqReq,
  output logic               swIrqOut
);
  ctrlStrobe_t strobe;

  fiq_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobe(strobe)
  );

  fiq_bank_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .srcIn(srcIn),
    .rdData(rdData), .fiqReq(fiqReq), .swIrqOut(swIrqOut)
  );
endmodule

// File: tb/tb_fiq_bank.sv
module tb_fiq_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0, srcIn = '0;
  logic [31:0] rdData;
  logic        fiqReq, swIrqOut;

  int total = 0, bad = 0;
  bit done = 0;

  fiq_bank dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .srcIn(srcIn), .fiqReq(fiqReq), .swIrqOut(swIrqOut));

  always #10 clk = ~clk;

  // Behavioural reference model
  bit [31:0] mEn;
  bit        mSwFiq, mSwIrq, mReq;

  function automatic bit [31:0] rawOf();
    return srcIn | (mSwFiq ? 32'h2 : 32'h0);
  endfunction

  function automatic bit [31:0] expRead();
    if (!rdEn) return 0;
    case (addr)
      12'h100: return rawOf() & mEn;
      12'h104: return rawOf();
      12'h108: return mEn;
      12'h110: return {29'd0, mSwFiq, mSwIrq, 1'b0};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn <= 0; mSwFiq <= 0; mSwIrq <= 0; mReq <= 0;
    end else begin
      mReq <= |(rawOf() & mEn);
      if (wrEn) begin
        case (addr)
          12'h108: mEn <= mEn | wrData;
          12'h10C: mEn <= mEn & ~wrData;
          12'h110: begin mSwFiq <= wrData[2]; mSwIrq <= wrData[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      check("R5 fiqReq", {31'd0, fiqReq}, {31'd0, mReq});
      check("R6 swIrqOut", {31'd0, swIrqOut}, {31'd0, mSwIrq});
      check("R8 rdData", rdData, expRead());
    end
  end

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0; addr = '0; wrData = '0;
  endtask

  task automatic busRead(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rdEn = 1; addr = a;
    #4 check(tag, rdData, exp);
    @(negedge clk); rdEn = 0; addr = '0;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 fiqReq reset", {31'd0, fiqReq}, 32'd0);
    check("R1 swIrqOut reset", {31'd0, swIrqOut}, 32'd0);
    rstN = 1;
    busRead(12'h108, 32'h0, "R1 enable reset");
    busRead(12'h110, 32'h0, "R1 swcfg reset");
    // R2 set and no-effect of zeros
    busWrite(12'h108, 32'h0000_00F0);
    busWrite(12'h108, 32'h0000_0003);
    busRead(12'h108, 32'h0000_00F3, "R2 set accumulates");
    busWrite(12'h108, 32'h0);
    busRead(12'h108, 32'h0000_00F3, "R2 zero write no effect");
    // R3 clear
    busWrite(12'h10C, 32'h0000_0030);
    busRead(12'h108, 32'h0000_00C3, "R3 clear selected");
    busRead(12'h10C, 32'h0, "R3 clear reads zero");
    // R4 status and R5 latency
    @(negedge clk); srcIn = 32'h0000_0100;
    @(negedge clk); #3 check("R5 masked source no req", {31'd0, fiqReq}, 32'd0);
    srcIn = 32'h0000_0180;
    #1 check("R5 req lags one edge", {31'd0, fiqReq}, 32'd0);
    @(negedge clk); #3 check("R5 req after edge", {31'd0, fiqReq}, 32'd1);
    busRead(12'h100, 32'h0000_0080, "R4 status and");
    busWrite(12'h100, 32'hFFFF_FFFF);
    busRead(12'h108, 32'h0000_00C3, "R4 status write ignored");
    srcIn = 32'h0;
    // R6 / R7 software source
    busWrite(12'h110, 32'hFFFF_FFFF);
    busRead(12'h110, 32'h0000_0006, "R6 reserved read zero");
    check("R6 swIrqOut set", {31'd0, swIrqOut}, 32'd1);
    busRead(12'h104, 32'h0000_0002, "R7 raw shows injected");
    busRead(12'h100, 32'h0000_0002, "R6 status shows injected");
    busWrite(12'h104, 32'hFFFF_FFFF);
    busRead(12'h108, 32'h0000_00C3, "R7 raw write ignored");
    busWrite(12'h110, 32'h0000_0002);
    busRead(12'h104, 32'h0, "R6 injection removed");
    // R8 unmapped
    busWrite(12'h204, 32'hFFFF_FFFF);
    busRead(12'h204, 32'h0, "R8 unmapped read");
    busRead(12'h108, 32'h0000_00C3, "R8 unmapped write ignored");
    busWrite(12'h10C, 32'hFFFF_FFFF);
    busRead(12'h108, 32'h0, "R3 clear all");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule